// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing controller of a byte-wide serial EEPROM. It runs on a fast system clock and synchronizes the two bus lines into that clock domain. It detects start and stop conditions on the lines and shifts bytes in on SCL rising edges. It answers with an open-drain enable on SDA, changing that enable only after SCL falls. A transfer begins with a select byte. The block acknowledges the select byte only when its upper nibble is the fixed code `1010` and its next three bits equal the three strap inputs, so up to eight devices can share one bus. Bit 0 of the select byte is the direction bit, where 1 means read.

A write transfer carries a two-byte word address, high byte first, followed by up to one page of data. The data bytes go into a page buffer. The low address bits advance inside the page and wrap there. On the stop that ends the write, the buffered bytes are copied into the array. A self-timed busy period, counted in system clocks, runs alongside that copy, and no select byte is acknowledged until it ends. A master can poll for completion this way.

A read transfer returns the byte at the current pointer and keeps returning bytes for as long as the master acknowledges, stepping through the whole array and wrapping from the last address to 0. A write-lock input that is high at the closing stop leaves the array untouched. The array depth is a parameter; address bits above it are ignored.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A transfer is accepted only after a start condition (SDA falling while SCL is high). A byte clocked without a preceding start is not acknowledged. After a stop condition (SDA rising while SCL is high), SDA is released.
- R2: The select byte is acknowledged only when bits 7:4 are `1010` and bits 3:1 equal `strap_i[2:0]`. On a mismatch the slave does not drive SDA again until the next start.
- R3: During the ninth clock of every accepted select byte, address byte and write-data byte, the slave drives SDA low.
- R4: `sda_oe_o` changes only while SCL is low.
- R5: A write of one byte at a 16-bit address (sent MSB first), read back by a random read at that address, returns the byte. Address bits at and above `ADDR_W` are ignored.
- R6: A page write of N bytes (N from 1 to 128) stores them at consecutive addresses. The low 7 address bits wrap inside the 128-byte page, and bytes not written keep their values.
- R7: A sequential read returns consecutive bytes, wraps from address 2^ADDR_W-1 to 0, and ends with SDA released when the master answers a byte with NACK and then sends a stop.
- R8: A read with the direction bit set and no address phase starts at the address after the last byte written or read.
- R9: When `wr_lock_i` is 1 at the closing stop, the array is unchanged and no busy period starts.
- R10: After a stop that ends a write of at least one unlocked data byte, select bytes are not acknowledged for `TWR_CYCLES` clocks. After that period they are acknowledged again.
- R11: A write transfer that carries no data bytes, or that is cut off by a repeated start, changes no array byte and starts no busy period.
- R12: After reset, SDA is released and the first matching select byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Device select straps, compared with select-byte bits 3:1 |
| wr_lock_i | input | 1 | High blocks array updates at the closing stop |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Directed transfers target the page edges, the end of the array and the first address, so that in-page wrapping (R6) can be told apart from linear sequential-read wrapping (R7). Select bytes with a wrong strap field or a wrong fixed code check the address match. Polling directly after a write, after a locked write and after a write cut off by a repeated start separates a real busy period from one that should never start. Constrained-random short page writes at random offsets, with random unused upper address bits, are then each read back at their start address. Checks against a bench reference array expose misplaced bytes, wrong pointer steps and ignored-bit decoding.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK_WAIT,
      ST_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_TX_NEXT
   } bus_state_t;

   typedef enum logic [1:0] {
      K_DEV,
      K_AHI,
      K_ALO,
      K_DATA
   } byte_kind_t;

   localparam logic [3:0] SELECT_CODE = 4'b1010;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int SYNC_STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   if (SYNC_STAGES < 1) begin : g_bad_stages
      $error("i2c_line_sync: SYNC_STAGES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] scl_ch;
   logic [SYNC_STAGES-1:0] sda_ch;
   logic                   scl_d;
   logic                   sda_d;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ch[g] <= 1'b1;
               sda_ch[g] <= 1'b1;
            end else begin
               scl_ch[g] <= scl_i;
               sda_ch[g] <= sda_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ch[g] <= 1'b1;
               sda_ch[g] <= 1'b1;
            end else begin
               scl_ch[g] <= scl_ch[g-1];
               sda_ch[g] <= sda_ch[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_ch[SYNC_STAGES-1];
         sda_d <= sda_ch[SYNC_STAGES-1];
      end
   end

   assign scl_o      = scl_ch[SYNC_STAGES-1];
   assign sda_o      = sda_ch[SYNC_STAGES-1];
   assign scl_rise_o = scl_o & ~scl_d;
   assign scl_fall_o = ~scl_o & scl_d;
   assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
   assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_geom
      $error("eeprom_cell_array: widths must be positive");
   end

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) cells[waddr_i] <= wdata_i;
   end

   assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/eeprom_page_latch.sv
module eeprom_page_latch #(
   parameter int ADDR_W = 11,
   parameter int PAGE_W = 7
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear_i,
   input  logic                     load_i,
   input  logic [PAGE_W-1:0]        load_idx_i,
   input  logic [7:0]               load_data_i,
   input  logic                     commit_i,
   input  logic [ADDR_W-PAGE_W-1:0] commit_page_i,
   output logic                     mem_we_o,
   output logic [ADDR_W-1:0]        mem_waddr_o,
   output logic [7:0]               mem_wdata_o,
   output logic                     active_o
);

   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int PG_NUM_W   = ADDR_W - PAGE_W;

   if (PAGE_W < 1 || PG_NUM_W < 1) begin : g_bad_page
      $error("eeprom_page_latch: page must be smaller than the array");
   end

   logic [7:0]            pbuf [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] mask;
   logic [PAGE_W-1:0]     walk;
   logic [PG_NUM_W-1:0]   page_q;
   logic                  active;

   always_ff @(posedge clk) begin
      if (load_i) pbuf[load_idx_i] <= load_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask   <= '0;
         walk   <= '0;
         page_q <= '0;
         active <= 1'b0;
      end else begin
         if (commit_i) begin
            active <= 1'b1;
            walk   <= '0;
            page_q <= commit_page_i;
         end else if (active) begin
            walk <= walk + 1'b1;
            if (walk == {PAGE_W{1'b1}}) begin
               active <= 1'b0;
               mask   <= '0;
            end
         end
         if (clear_i) begin
            mask <= '0;
         end else if (load_i) begin
            mask[load_idx_i] <= 1'b1;
         end
      end
   end

   assign mem_we_o    = active & mask[walk];
   assign mem_waddr_o = {page_q, walk};
   assign mem_wdata_o = pbuf[walk];
   assign active_o    = active;

   assert_commit_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |-> !active)
      else $error("commit requested while a commit walk is running");

   assert_no_load_in_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> !(load_i || clear_i))
      else $error("page buffer touched during the commit walk");

endmodule

// File: rtl/eeprom_write_timer.sv
module eeprom_write_timer #(
   parameter int TWR_CYCLES = 500000
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);

   localparam int CW = $clog2(TWR_CYCLES + 1);

   if (TWR_CYCLES < 1) begin : g_bad_twr
      $error("eeprom_write_timer: TWR_CYCLES must be positive");
   end

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (start_i) begin
         remain <= CW'(TWR_CYCLES);
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign busy_o = (remain != '0);

   assert_busy_follows_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o)
      else $error("busy did not follow the write start");

   assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o)
      else $error("write cycle restarted while busy");

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
   import eeprom_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int PAGE_W      = 7,
   parameter int TWR_CYCLES  = 500000,
   parameter int SYNC_STAGES = 2
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] strap_i,
   input  logic       wr_lock_i,
   output logic       sda_oe_o
);

   localparam int HI_W       = ADDR_W - 8;
   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int PG_NUM_W   = ADDR_W - PAGE_W;

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_aw
      $error("eeprom_i2c_slave: ADDR_W must be within 9..16");
   end
   if (PAGE_W < 1 || PAGE_W > 8 || PAGE_W >= ADDR_W) begin : g_bad_pw
      $error("eeprom_i2c_slave: PAGE_W out of range");
   end
   if (TWR_CYCLES <= PAGE_BYTES) begin : g_bad_twr
      $error("eeprom_i2c_slave: write time must cover the page commit walk");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic busy;
   logic [7:0] rdata;
   logic mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [7:0] mem_wdata;
   logic commit_active;

   bus_state_t        st;
   byte_kind_t        kind, nkind;
   logic [2:0]        bit_cnt;
   logic [6:0]        shreg;
   logic [7:0]        txsh;
   logic [ADDR_W-1:0] ptr;
   logic [HI_W-1:0]   addr_hi;
   logic              go_tx, has_data, oe_q;

   logic [7:0] rx_byte;
   logic       byte_done, sel_ok, latch_clear, latch_load, commit_go;

   i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_o      (scl_s),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_det),
      .stop_o     (stop_det)
   );

   assign rx_byte     = {shreg, sda_s};
   assign byte_done   = (st == ST_RX) && scl_rise && (bit_cnt == 3'd7);
   assign sel_ok      = (rx_byte[7:4] == SELECT_CODE) && (rx_byte[3:1] == strap_i) && !busy;
   assign latch_clear = byte_done && (kind == K_ALO);
   assign latch_load  = byte_done && (kind == K_DATA);
   assign commit_go   = stop_det && has_data && !wr_lock_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         kind     <= K_DEV;
         nkind    <= K_DEV;
         bit_cnt  <= '0;
         shreg    <= '0;
         txsh     <= '0;
         ptr      <= '0;
         addr_hi  <= '0;
         go_tx    <= 1'b0;
         has_data <= 1'b0;
         oe_q     <= 1'b0;
      end else if (stop_det) begin
         st       <= ST_IDLE;
         oe_q     <= 1'b0;
         has_data <= 1'b0;
      end else if (start_det) begin
         st       <= ST_RX;
         kind     <= K_DEV;
         bit_cnt  <= '0;
         oe_q     <= 1'b0;
         has_data <= 1'b0;
      end else begin
         unique case (st)
            ST_RX: begin
               if (scl_rise) begin
                  shreg   <= rx_byte[6:0];
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == 3'd7) begin
                     st    <= ST_ACK_WAIT;
                     go_tx <= 1'b0;
                     unique case (kind)
                        K_DEV: begin
                           if (sel_ok) begin
                              go_tx <= rx_byte[0];
                              nkind <= K_AHI;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        K_AHI: begin
                           addr_hi <= rx_byte[HI_W-1:0];
                           nkind   <= K_ALO;
                        end
                        K_ALO: begin
                           ptr   <= {addr_hi, rx_byte};
                           nkind <= K_DATA;
                        end
                        K_DATA: begin
                           ptr      <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                           has_data <= 1'b1;
                           nkind    <= K_DATA;
                        end
                        default: st <= ST_IDLE;
                     endcase
                  end
               end
            end
            ST_ACK_WAIT: begin
               if (scl_fall) begin
                  oe_q <= 1'b1;
                  st   <= ST_ACK;
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  kind    <= nkind;
                  bit_cnt <= '0;
                  if (go_tx) begin
                     txsh <= {rdata[6:0], 1'b0};
                     oe_q <= ~rdata[7];
                     ptr  <= ptr + 1'b1;
                     st   <= ST_TX;
                  end else begin
                     oe_q <= 1'b0;
                     st   <= ST_RX;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == 3'd7) begin
                     oe_q <= 1'b0;
                     st   <= ST_TX_ACK;
                  end else begin
                     oe_q <= ~txsh[7];
                     txsh <= {txsh[6:0], 1'b0};
                  end
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) begin
                  st <= sda_s ? ST_IDLE : ST_TX_NEXT;
               end
            end
            ST_TX_NEXT: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  txsh    <= {rdata[6:0], 1'b0};
                  oe_q    <= ~rdata[7];
                  ptr     <= ptr + 1'b1;
                  st      <= ST_TX;
               end
            end
            default: ;
         endcase
      end
   end

   eeprom_page_latch #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_latch (
      .clk           (clk),
      .rst_n         (rst_n),
      .clear_i       (latch_clear),
      .load_i        (latch_load),
      .load_idx_i    (ptr[PAGE_W-1:0]),
      .load_data_i   (rx_byte),
      .commit_i      (commit_go),
      .commit_page_i (ptr[ADDR_W-1:PAGE_W]),
      .mem_we_o      (mem_we),
      .mem_waddr_o   (mem_waddr),
      .mem_wdata_o   (mem_wdata),
      .active_o      (commit_active)
   );

   eeprom_write_timer #(.TWR_CYCLES(TWR_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (commit_go),
      .busy_o  (busy)
   );

   eeprom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
      .clk     (clk),
      .we_i    (mem_we),
      .waddr_i (mem_waddr),
      .wdata_i (mem_wdata),
      .raddr_i (ptr),
      .rdata_o (rdata)
   );

   assign sda_oe_o = oe_q;

   assert_oe_rise_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> !$past(scl_s))
      else $error("SDA pulled low while SCL high");

   assert_release_after_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !oe_q)
      else $error("SDA still driven after stop");

   assert_busy_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ACK_WAIT && kind == K_DEV) |-> !busy)
      else $error("select acknowledged during write cycle");

   assert_commit_implies_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      commit_active |-> busy)
      else $error("commit walk outlived the busy period");

   assert_ptr_in_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(latch_load) && !$past(stop_det) && !$past(start_det))
         |-> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))
      else $error("page write left its page");

endmodule

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;

   localparam int AW    = 11;
   localparam int TWR   = 600;
   localparam int DEPTH = 1 << AW;
   localparam logic [2:0] STRAP = 3'b101;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic wr_lock = 1'b0;
   logic sda_oe;
   logic sda_line;

   assign sda_line = sda_m & ~sda_oe;

   always #5 clk = ~clk;

   eeprom_i2c_slave #(
      .ADDR_W(AW), .PAGE_W(7), .TWR_CYCLES(TWR), .SYNC_STAGES(2)
   ) i_eeprom_i2c_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl),
      .sda_i     (sda_line),
      .strap_i   (STRAP),
      .wr_lock_i (wr_lock),
      .sda_oe_o  (sda_oe)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int oe_viol = 0;
   logic prev_oe = 1'b0;

   logic [7:0]    ref_mem [DEPTH];
   bit            ref_ok  [DEPTH];
   logic [AW-1:0] ref_ptr = '0;
   logic [7:0]    wdat [16];

   function automatic logic [AW-1:0] page_inc(input logic [AW-1:0] a);
      return {a[AW-1:7], a[6:0] + 7'd1};
   endfunction

   function automatic logic [7:0] sel(input logic rd, input logic [2:0] s);
      return {4'b1010, s, rd};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clk_bit(input logic drv, output logic smp);
      tick(3); sda_m = drv;
      tick(7); scl = 1'b1;
      tick(5); smp = sda_line;
      tick(5); scl = 1'b0;
   endtask

   task automatic bus_start();
      tick(3); sda_m = 1'b1;
      tick(7); scl = 1'b1;
      tick(10); sda_m = 1'b0;
      tick(10); scl = 1'b0;
   endtask

   task automatic bus_stop();
      tick(3); sda_m = 1'b0;
      tick(7); scl = 1'b1;
      tick(10); sda_m = 1'b1;
      tick(10);
   endtask

   task automatic wbyte(input logic [7:0] b, output bit ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      ack = (s === 1'b0);
   endtask

   task automatic rbyte(input bit mack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         b[i] = s;
      end
      clk_bit(!mack, s);
   endtask

   // write transfer: select, two address bytes, n data bytes, optional stop
   task automatic write_txn(input logic [15:0] a, input int n, input bit do_stop);
      bit ack;
      logic [AW-1:0] p;
      bus_start();
      wbyte(sel(1'b0, STRAP), ack); check(ack, "R3 select ack", ack, 1);
      wbyte(a[15:8], ack);          check(ack, "R3 high address ack", ack, 1);
      wbyte(a[7:0], ack);           check(ack, "R3 low address ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         wbyte(wdat[i], ack);       check(ack, "R3 data ack", ack, 1);
      end
      if (do_stop) bus_stop();
      p = a[AW-1:0];
      for (int i = 0; i < n; i++) begin
         if (do_stop && !wr_lock) begin
            ref_mem[p] = wdat[i];
            ref_ok[p]  = 1'b1;
         end
         p = page_inc(p);
      end
      ref_ptr = p;
   endtask

   // read from the current pointer (start + select read), n bytes
   task automatic read_body(input int n, input string tag);
      bit ack;
      logic [7:0] b;
      bus_start();
      wbyte(sel(1'b1, STRAP), ack); check(ack, "R3 read select ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         rbyte(i != n - 1, b);
         if (ref_ok[ref_ptr]) check(b === ref_mem[ref_ptr], tag, b, ref_mem[ref_ptr]);
         ref_ptr = ref_ptr + 1'b1;
      end
      bus_stop();
      tick(2);
      check(sda_oe === 1'b0, "R7 SDA released after NACK and stop", sda_oe, 0);
   endtask

   task automatic read_random(input logic [15:0] a, input int n, input string tag);
      write_txn(a, 0, 1'b0);
      read_body(n, tag);
   endtask

   task automatic probe(output bit ack);
      bus_start();
      wbyte(sel(1'b0, STRAP), ack);
      bus_stop();
   endtask

   task automatic settle();
      tick(TWR + 60);
   endtask

   always @(negedge clk) begin
      if (rst_n && (sda_oe !== prev_oe) && scl) oe_viol++;
      prev_oe <= sda_oe;
   end

   task automatic finish_run();
      check(oe_viol == 0, "R4 SDA enable changed while SCL high", oe_viol, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc > 195000) begin
         check(1'b0, "watchdog expired", cyc, 195000);
         finish_run();
      end
   end

   initial begin
      bit ack;
      logic [15:0] a;
      int n;
      void'($urandom(32'h5EED_0A11));
      for (int i = 0; i < DEPTH; i++) ref_ok[i] = 1'b0;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R12: reset state
      check(sda_oe === 1'b0, "R12 SDA released after reset", sda_oe, 0);
      probe(ack);
      check(ack, "R12 first select acknowledged", ack, 1);

      // R1: byte without start is ignored
      wbyte(sel(1'b0, STRAP), ack);
      check(!ack, "R1 no ack without start", ack, 0);
      bus_stop();
      check(sda_oe === 1'b0, "R1 released after stop", sda_oe, 0);

      // R2: strap mismatch and wrong fixed code
      bus_start();
      wbyte(sel(1'b0, 3'b100), ack);
      check(!ack, "R2 strap mismatch not acked", ack, 0);
      wbyte(8'h00, ack);
      check(!ack, "R2 silent until next start", ack, 0);
      bus_stop();
      bus_start();
      wbyte({4'b1011, STRAP, 1'b0}, ack);
      check(!ack, "R2 wrong fixed code not acked", ack, 0);
      bus_stop();

      // R5: byte write and random read, upper bits ignored
      wdat[0] = 8'hA5;
      write_txn(16'h0005, 1, 1'b1);
      settle();
      read_random(16'h0005, 1, "R5 byte readback");
      read_random(16'hF805, 1, "R5 upper address bits ignored");

      // R10: busy polling
      wdat[0] = 8'h3E;
      write_txn(16'h0010, 1, 1'b1);
      probe(ack);
      check(!ack, "R10 select nacked while busy", ack, 0);
      settle();
      probe(ack);
      check(ack, "R10 select acked after write time", ack, 1);
      read_random(16'h0010, 1, "R10 data after write cycle");

      // R6: page write wrapping within page, neighbour untouched
      wdat[0] = 8'h11; write_txn(16'h0080, 1, 1'b1); settle();
      wdat[0] = 8'h22; write_txn(16'h0002, 1, 1'b1); settle();
      wdat[0] = 8'hC0; wdat[1] = 8'hC1; wdat[2] = 8'hC2; wdat[3] = 8'hC3;
      write_txn(16'h007E, 4, 1'b1);
      settle();
      // R8: current-address read continues after last written byte (0x002)
      read_body(1, "R8 current address after page write");
      read_random(16'h007E, 2, "R6 bytes at page end");
      read_random(16'h0000, 2, "R6 bytes wrapped to page start");
      read_random(16'h0080, 1, "R6 next page untouched");
      read_random(16'h0005, 1, "R6 unwritten byte kept");
      // R8: current-address read after a read continues from there (0x006)
      wdat[0] = 8'h66; write_txn(16'h0006, 1, 1'b1); settle();
      read_random(16'h0005, 1, "R8 setup read");
      read_body(1, "R8 current address after read");

      // R7: sequential read wraps at end of array
      wdat[0] = 8'hFE; wdat[1] = 8'hFF;
      write_txn(16'h07FE, 2, 1'b1);
      settle();
      read_random(16'h07FE, 4, "R7 sequential read across array end");

      // R9: write lock
      wr_lock = 1'b1;
      wdat[0] = 8'h3C;
      write_txn(16'h0005, 1, 1'b1);
      probe(ack);
      check(ack, "R9 no busy after locked write", ack, 1);
      wr_lock = 1'b0;
      read_random(16'h0005, 1, "R9 locked byte unchanged");

      // R11: repeated start drops data; address-only write leaves no busy
      wdat[0] = 8'h44; write_txn(16'h0040, 1, 1'b1); settle();
      wdat[0] = 8'h77;
      write_txn(16'h0040, 1, 1'b0);
      ref_ptr = 11'h041;
      read_body(1, "R11 read after cut-off write");
      probe(ack);
      check(ack, "R11 no busy after cut-off write", ack, 1);
      write_txn(16'h0040, 0, 1'b1);
      probe(ack);
      check(ack, "R11 no busy after address-only write", ack, 1);
      read_random(16'h0040, 1, "R11 cut-off byte not stored");

      // random page writes with readback
      for (int it = 0; it < 14; it++) begin
         a = {5'($urandom), 2'b01, 2'($urandom), 7'($urandom)};
         n = 1 + int'($urandom % 6);
         for (int k = 0; k < n; k++) wdat[k] = 8'($urandom);
         write_txn(a, n, 1'b1);
         settle();
         read_random(a, n, "R6 random page write readback");
      end

      finish_run();
   end

endmodule